// File: doc/BRIEF.md
# Parallel Nibble Handshake Port

This block is the device-side end of a four-bit parallel handshake link to a disk drive. A local controller loads bytes for the drive into a send register and collects bytes from the drive out of a receive register. The drive owns two active-low strobes, one to pull data and one to push data. The block owns an active-low acknowledge. Every byte crosses the link as two nibbles, low nibble first, and each nibble runs its own four-phase strobe/acknowledge exchange. The pins are open-drain, so the block drives output enables and samples the pin levels through a two-flop synchronizer.

When the drive pulls data and the send register is empty, the block raises a read interrupt and withholds acknowledge until the controller loads a byte. When the drive pushes a byte, the block sets a receive-full flag and raises a write interrupt. While that flag is set, the next push is held off. A mode pin, when high, puts the lines in a passive legacy select mode: the engine lets go of every pin and the status data field shows the physical address inputs. When the mode pin falls, the block announces itself with an acknowledge pulse. A manual-enable input gives the pins to firmware and parks the engine. A live status byte reflects the synchronized pin levels.

Top module: `nib_encl_port`

## Requirements
- R1: After reset, ack_oe, d_oe, rfull, wfull, rirq and wirq are all 0.
- R2: A drive push is two nibbles on d_i, low nibble first. For each nibble the block raises ack_oe after wr_strb_n goes low and drops it after wr_strb_n returns high. After the second nibble, wfull=1, wirq=1 and rx_byte holds {second, first}. After the first nibble alone, wfull stays 0.
- R3: A one-cycle ctl_take pulse clears wfull and wirq.
- R4: While wfull=1, a new push (wr_strb_n low) gets no acknowledge until ctl_take. After ctl_take the push completes normally.
- R5: When rd_strb_n goes low and rfull=1, the block drives d_o with d_oe=1 and raises ack_oe. The first nibble is the low nibble and the second is the high nibble. rfull returns to 0 when the second acknowledge is released.
- R6: On a pull, d_oe is high for at least SETUP_CYC clocks (5 clocks, 100 ns at 50 MHz) before ack_oe rises.
- R7: A pull with rfull=0 sets rirq=1 and gets no acknowledge. A ctl_load pulse then clears rirq, sets rfull and lets the pull proceed with the loaded byte.
- R8: A ctl_load while rfull=1 is ignored: the byte already in the send register is the one delivered.
- R9: While par_mode_n is high and manual mode is off, ack_oe=0 and d_oe=0, and the strobes have no effect on wfull, rfull or the handshake.
- R10: After par_mode_n falls, ack_oe rises within 1 us and stays high for ANN_NS (400 ns, 20 clocks at 50 MHz), then drops.
- R11: The status byte stat is laid out as follows:
  - bit 7: synchronized par_mode_n
  - bit 6: synchronized rd_strb_n
  - bit 5: synchronized wr_strb_n
  - bit 4: acknowledge pin level (~ack_oe)
  - bits 3:0: pa_i when par_mode_n is high, otherwise the d_i pins
- R12: With man_en=1, ack_oe, d_oe and d_o follow man_ack, man_d_oe and man_d. Strobes then cause no acknowledge and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode_n | input | 1 | Mode pin: low = nibble handshake, high = legacy select lines |
| rd_strb_n | input | 1 | Drive read strobe, active low |
| wr_strb_n | input | 1 | Drive write strobe, active low |
| d_i | input | 4 | Sampled level of the data pins |
| pa_i | input | 4 | Physical address inputs |
| d_o | output | 4 | Data value driven when d_oe is 1 |
| d_oe | output | 1 | Output enable for the data pins |
| ack_oe | output | 1 | Pulls the acknowledge pin low when 1 |
| man_en | input | 1 | Gives the pins to firmware |
| man_ack | input | 1 | Firmware acknowledge enable |
| man_d_oe | input | 1 | Firmware data output enable |
| man_d | input | 4 | Firmware data value |
| ctl_load | input | 1 | Load ctl_wdata into the send register |
| ctl_wdata | input | 8 | Byte for the drive |
| ctl_take | input | 1 | Controller has read rx_byte; clears wfull and wirq |
| rx_byte | output | 8 | Last byte received from the drive |
| rfull | output | 1 | Send register holds a byte not yet delivered |
| wfull | output | 1 | Receive register holds an unread byte |
| rirq | output | 1 | Read interrupt: the drive wants a byte |
| wirq | output | 1 | Write interrupt: a byte has arrived |
| stat | output | 8 | Live pin status |

## Verification
The assertions watch the following on every cycle:
- the data setup window in front of every read acknowledge;
- that wirq never stands without wfull;
- that wfull falls only after ctl_take and rfull rises only after ctl_load;
- that the pins stay released in legacy mode;
- that the engine stays parked under manual control.

Only the bench's scenarios can show:
- the nibble order and byte assembly in each direction;
- the hold-off behaviour against late loads and reads;
- the ignored second load;
- the announce pulse's timing;
- the status field mapping.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_ANNC     = 3'd1,
    ST_IDLE     = 3'd2,
    ST_RD_WAIT  = 3'd3,
    ST_RD_SETUP = 3'd4,
    ST_RD_ACK   = 3'd5,
    ST_WR_WAIT  = 3'd6,
    ST_WR_ACK   = 3'd7
  } nib_st_e;
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= a;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign y = stg[STAGES-1];
endmodule

// File: rtl/nib_hs_fsm.sv
module nib_hs_fsm
  import nib_pkg::*;
#(
  parameter int SETUP_CYC = 5,
  parameter int ANN_CYC   = 20,
  parameter int CNT_W     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_n_s,
  input  logic       rd_n_s,
  input  logic       wr_n_s,
  input  logic [3:0] d_s,
  input  logic       man_en,
  input  logic       ctl_load,
  input  logic [7:0] ctl_wdata,
  input  logic       ctl_take,
  output logic       eng_ack,
  output logic       eng_d_oe,
  output logic [3:0] eng_d,
  output logic       rfull,
  output logic       wfull,
  output logic       rirq,
  output logic       wirq,
  output logic [7:0] rx_byte
);
  nib_st_e    st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic       rd_half_q, rd_half_n, wr_half_q, wr_half_n;
  logic [7:0] tx_q, tx_n, rx_q, rx_n;
  logic [3:0] lo_q, lo_n;
  logic       rfull_q, rfull_n, wfull_q, wfull_n;
  logic       rirq_q, rirq_n, wirq_q, wirq_n;
  logic       live, wr_cap, rd_done, wr_done, clr_half, load_ok;

  // next-state selection
  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_OFF:      if (!mode_n_s && !man_en) st_n = ST_ANNC;
      ST_ANNC:     if (cnt_q == CNT_W'(ANN_CYC - 1)) st_n = ST_IDLE;
      ST_IDLE: begin
        if (!rd_n_s)      st_n = rfull_q ? ST_RD_SETUP : ST_RD_WAIT;
        else if (!wr_n_s) st_n = (wfull_q && !wr_half_q) ? ST_WR_WAIT : ST_WR_ACK;
      end
      ST_RD_WAIT: begin
        if (rd_n_s)       st_n = ST_IDLE;
        else if (rfull_q) st_n = ST_RD_SETUP;
      end
      ST_RD_SETUP: begin
        if (rd_n_s)                              st_n = ST_IDLE;
        else if (cnt_q == CNT_W'(SETUP_CYC - 1)) st_n = ST_RD_ACK;
      end
      ST_RD_ACK:   if (rd_n_s) st_n = ST_IDLE;
      ST_WR_WAIT: begin
        if (wr_n_s)        st_n = ST_IDLE;
        else if (!wfull_q) st_n = ST_WR_ACK;
      end
      ST_WR_ACK:   if (wr_n_s) st_n = ST_IDLE;
      default:     st_n = ST_OFF;
    endcase
    if (man_en && st_q != ST_OFF) st_n = ST_IDLE;
    if (mode_n_s)                 st_n = ST_OFF;
  end

  // datapath next values
  always_comb begin
    live     = !mode_n_s && !man_en;
    wr_cap   = (st_n == ST_WR_ACK) && (st_q != ST_WR_ACK);
    rd_done  = (st_q == ST_RD_ACK) && rd_n_s && live;
    wr_done  = (st_q == ST_WR_ACK) && wr_n_s && live;
    clr_half = (st_n == ST_OFF) || man_en;
    load_ok  = ctl_load && !rfull_q;

    if (st_n != st_q)                                cnt_n = '0;
    else if (st_q == ST_ANNC || st_q == ST_RD_SETUP) cnt_n = cnt_q + 1'b1;
    else                                             cnt_n = cnt_q;

    rd_half_n = clr_half ? 1'b0 : (rd_done ? ~rd_half_q : rd_half_q);
    wr_half_n = clr_half ? 1'b0 : (wr_done ? ~wr_half_q : wr_half_q);

    tx_n    = load_ok ? ctl_wdata : tx_q;
    rfull_n = load_ok ? 1'b1 : ((rd_done && rd_half_q) ? 1'b0 : rfull_q);
    if (load_ok)                                       rirq_n = 1'b0;
    else if (st_n == ST_RD_WAIT && st_q != ST_RD_WAIT) rirq_n = 1'b1;
    else                                               rirq_n = rirq_q;

    lo_n    = (wr_cap && !wr_half_q) ? d_s : lo_q;
    rx_n    = (wr_cap && wr_half_q) ? {d_s, lo_q} : rx_q;
    wfull_n = (wr_cap && wr_half_q) ? 1'b1 : (ctl_take ? 1'b0 : wfull_q);
    wirq_n  = (wr_cap && wr_half_q) ? 1'b1 : (ctl_take ? 1'b0 : wirq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OFF;
      cnt_q     <= '0;
      rd_half_q <= 1'b0;
      wr_half_q <= 1'b0;
      tx_q      <= '0;
      rx_q      <= '0;
      lo_q      <= '0;
      rfull_q   <= 1'b0;
      wfull_q   <= 1'b0;
      rirq_q    <= 1'b0;
      wirq_q    <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      rd_half_q <= rd_half_n;
      wr_half_q <= wr_half_n;
      if (load_ok) tx_q <= tx_n;
      if (wr_cap)  rx_q <= rx_n;
      if (wr_cap)  lo_q <= lo_n;
      rfull_q   <= rfull_n;
      wfull_q   <= wfull_n;
      rirq_q    <= rirq_n;
      wirq_q    <= wirq_n;
    end
  end

  assign eng_ack  = (st_q == ST_ANNC) || (st_q == ST_RD_ACK) || (st_q == ST_WR_ACK);
  assign eng_d_oe = (st_q == ST_RD_SETUP) || (st_q == ST_RD_ACK);
  assign eng_d    = rd_half_q ? tx_q[7:4] : tx_q[3:0];
  assign rfull    = rfull_q;
  assign wfull    = wfull_q;
  assign rirq     = rirq_q;
  assign wirq     = wirq_q;
  assign rx_byte  = rx_q;
endmodule

// File: rtl/nib_pinmux.sv
module nib_pinmux (
  input  logic       man_en,
  input  logic       man_ack,
  input  logic       man_d_oe,
  input  logic [3:0] man_d,
  input  logic       eng_ack,
  input  logic       eng_d_oe,
  input  logic [3:0] eng_d,
  input  logic       mode_n_s,
  input  logic       rd_n_s,
  input  logic       wr_n_s,
  input  logic [3:0] d_s,
  input  logic [3:0] pa_s,
  output logic       ack_oe,
  output logic       d_oe,
  output logic [3:0] d_o,
  output logic [7:0] stat
);
  always_comb begin
    if (man_en) begin
      ack_oe = man_ack;
      d_oe   = man_d_oe;
      d_o    = man_d;
    end else begin
      ack_oe = eng_ack;
      d_oe   = eng_d_oe;
      d_o    = eng_d;
    end
    stat = {mode_n_s, rd_n_s, wr_n_s, ~ack_oe, (mode_n_s ? pa_s : d_s)};
  end
endmodule

// File: rtl/nib_encl_port.sv
module nib_encl_port #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SETUP_NS = 100,
  parameter int ANN_NS   = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_mode_n,
  input  logic       rd_strb_n,
  input  logic       wr_strb_n,
  input  logic [3:0] d_i,
  input  logic [3:0] pa_i,
  output logic [3:0] d_o,
  output logic       d_oe,
  output logic       ack_oe,
  input  logic       man_en,
  input  logic       man_ack,
  input  logic       man_d_oe,
  input  logic [3:0] man_d,
  input  logic       ctl_load,
  input  logic [7:0] ctl_wdata,
  input  logic       ctl_take,
  output logic [7:0] rx_byte,
  output logic       rfull,
  output logic       wfull,
  output logic       rirq,
  output logic       wirq,
  output logic [7:0] stat
);
  localparam int CLK_MHZ   = CLK_HZ / 1_000_000;
  localparam int SETUP_RAW = (SETUP_NS * CLK_MHZ + 999) / 1000;
  localparam int ANN_RAW   = (ANN_NS * CLK_MHZ + 999) / 1000;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int ANN_CYC   = (ANN_RAW < 1) ? 1 : ANN_RAW;
  localparam int CNT_MAX   = (SETUP_CYC > ANN_CYC) ? SETUP_CYC : ANN_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int SYNC_W    = 11;

  logic [SYNC_W-1:0] sync_y;
  logic              mode_n_s, rd_n_s, wr_n_s;
  logic [3:0]        d_s, pa_s;
  logic              eng_ack, eng_d_oe;
  logic [3:0]        eng_d;

  nib_sync #(
    .W       (SYNC_W),
    .STAGES  (2),
    .RST_VAL (11'b111_0000_0000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .a     ({par_mode_n, rd_strb_n, wr_strb_n, d_i, pa_i}),
    .y     (sync_y)
  );

  assign {mode_n_s, rd_n_s, wr_n_s, d_s, pa_s} = sync_y;

  nib_hs_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .ANN_CYC   (ANN_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_n_s  (mode_n_s),
    .rd_n_s    (rd_n_s),
    .wr_n_s    (wr_n_s),
    .d_s       (d_s),
    .man_en    (man_en),
    .ctl_load  (ctl_load),
    .ctl_wdata (ctl_wdata),
    .ctl_take  (ctl_take),
    .eng_ack   (eng_ack),
    .eng_d_oe  (eng_d_oe),
    .eng_d     (eng_d),
    .rfull     (rfull),
    .wfull     (wfull),
    .rirq      (rirq),
    .wirq      (wirq),
    .rx_byte   (rx_byte)
  );

  nib_pinmux u_mux (
    .man_en   (man_en),
    .man_ack  (man_ack),
    .man_d_oe (man_d_oe),
    .man_d    (man_d),
    .eng_ack  (eng_ack),
    .eng_d_oe (eng_d_oe),
    .eng_d    (eng_d),
    .mode_n_s (mode_n_s),
    .rd_n_s   (rd_n_s),
    .wr_n_s   (wr_n_s),
    .d_s      (d_s),
    .pa_s     (pa_s),
    .ack_oe   (ack_oe),
    .d_oe     (d_oe),
    .d_o      (d_o),
    .stat     (stat)
  );
endmodule

// File: rtl/nib_encl_port_chk.sv
module nib_encl_port_chk #(
  parameter int SETUP_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic par_mode_n,
  input logic man_en,
  input logic ctl_take,
  input logic ctl_load,
  input logic ack_oe,
  input logic d_oe,
  input logic eng_ack,
  input logic eng_d_oe,
  input logic wfull,
  input logic wirq,
  input logic rfull
);
  logic [7:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               oe_run <= '0;
    else if (!eng_d_oe)       oe_run <= '0;
    else if (oe_run != 8'hFF) oe_run <= oe_run + 8'd1;
  end

  AST_WIRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wirq |-> wfull); // R2
  AST_WFULL_CLEAR_BY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wfull) |-> $past(ctl_take)); // R3
  AST_RFULL_SET_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfull) |-> $past(ctl_load)); // R7
  AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eng_ack) && eng_d_oe) |-> (oe_run >= 8'(SETUP_CYC))); // R6
  AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && $past(par_mode_n) && $past(par_mode_n, 2) && $past(par_mode_n, 3))
      |-> (!ack_oe && !d_oe)); // R9
  AST_MANUAL_PARKS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    (man_en && $past(man_en)) |-> (!eng_ack && !eng_d_oe)); // R12
endmodule

bind nib_encl_port nib_encl_port_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_mode_n (par_mode_n),
  .man_en     (man_en),
  .ctl_take   (ctl_take),
  .ctl_load   (ctl_load),
  .ack_oe     (ack_oe),
  .d_oe       (d_oe),
  .eng_ack    (eng_ack),
  .eng_d_oe   (eng_d_oe),
  .wfull      (wfull),
  .wirq       (wirq),
  .rfull      (rfull)
);

// File: tb/nib_encl_port_test.sv
module nib_encl_port_test;
  localparam int SETUP_EXP = 5;
  localparam int ANN_EXP   = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, par_mode_n, rd_strb_n, wr_strb_n;
  logic [3:0] drv_d, pa_i, d_o, man_d;
  logic       d_oe, ack_oe, man_en, man_ack, man_d_oe;
  logic       ctl_load, ctl_take;
  logic [7:0] ctl_wdata, rx_byte, stat;
  logic       rfull, wfull, rirq, wirq;
  wire  [3:0] d_bus = d_oe ? d_o : drv_d;

  nib_encl_port uut (
    .clk(clk), .rst_n(rst_n), .par_mode_n(par_mode_n), .rd_strb_n(rd_strb_n),
    .wr_strb_n(wr_strb_n), .d_i(d_bus), .pa_i(pa_i), .d_o(d_o), .d_oe(d_oe),
    .ack_oe(ack_oe), .man_en(man_en), .man_ack(man_ack), .man_d_oe(man_d_oe),
    .man_d(man_d), .ctl_load(ctl_load), .ctl_wdata(ctl_wdata), .ctl_take(ctl_take),
    .rx_byte(rx_byte), .rfull(rfull), .wfull(wfull), .rirq(rirq), .wirq(wirq),
    .stat(stat)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [7:0] join_nib(input logic [3:0] lo, input logic [3:0] hi);
    return {hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack(input logic lvl, input int lim, output int cyc);
    cyc = 0;
    while (ack_oe !== lvl && cyc < lim) begin
      tick(1);
      cyc++;
    end
  endtask

  task automatic wr_nib(input logic [3:0] nib, input string tag);
    int c;
    drv_d = nib;
    tick(2);
    wr_strb_n = 1'b0;
    wait_ack(1'b1, 60, c);
    chk({tag, " ack raised"}, 32'(c < 60), 1);
    wr_strb_n = 1'b1;
    wait_ack(1'b0, 60, c);
    chk({tag, " ack released"}, 32'(c < 60), 1);
  endtask

  task automatic rd_byte(output logic [7:0] got, output int setup_min);
    logic [3:0] nib [2];
    setup_min = 999;
    for (int i = 0; i < 2; i++) begin
      int c;
      int sc;
      c = 0;
      sc = 0;
      rd_strb_n = 1'b0;
      while (c < 200) begin
        tick(1);
        c++;
        if (ack_oe) break;
        if (d_oe) sc++;
      end
      chk("R5 read ack raised", 32'(ack_oe), 1);
      chk("R5 data driven at ack", 32'(d_oe), 1);
      nib[i] = d_bus;
      if (sc < setup_min) setup_min = sc;
      rd_strb_n = 1'b1;
      wait_ack(1'b0, 60, c);
      chk("R5 read ack released", 32'(c < 60), 1);
    end
    got = join_nib(nib[0], nib[1]);
  endtask

  task automatic pulse_take();
    ctl_take = 1'b1;
    tick(1);
    ctl_take = 1'b0;
  endtask

  task automatic pulse_load(input logic [7:0] b);
    ctl_wdata = b;
    ctl_load  = 1'b1;
    tick(1);
    ctl_load  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..: act=timeout exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, b, r;
    int c, d, smin;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; par_mode_n = 1'b1; rd_strb_n = 1'b1; wr_strb_n = 1'b1;
    drv_d = 4'h0; pa_i = 4'h5; man_en = 1'b0; man_ack = 1'b0; man_d_oe = 1'b0;
    man_d = 4'h0; ctl_load = 1'b0; ctl_take = 1'b0; ctl_wdata = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 ack_oe", 32'(ack_oe), 0);
    chk("R1 d_oe", 32'(d_oe), 0);
    chk("R1 flags", {28'd0, rfull, wfull, rirq, wirq}, 0);

    // R9 legacy mode ignores strobes; R11 shows pa
    drv_d = 4'h9;
    wr_strb_n = 1'b0;
    tick(20);
    chk("R9 no ack in legacy", 32'(ack_oe), 0);
    chk("R9 no data drive in legacy", 32'(d_oe), 0);
    chk("R9 wfull untouched", 32'(wfull), 0);
    chk("R11 stat mode bit", 32'(stat[7]), 1);
    chk("R11 stat pa field", 32'(stat[3:0]), 32'h5);
    chk("R11 stat wr strobe bit", 32'(stat[5]), 0);
    wr_strb_n = 1'b1;
    tick(4);

    // R10 announce pulse
    par_mode_n = 1'b0;
    wait_ack(1'b1, 60, c);
    chk("R10 ack within 1us", 32'(c <= 50), 1);
    d = 1;
    while (d < 100) begin
      tick(1);
      if (!ack_oe) break;
      d++;
    end
    chk("R10 announce length", 32'(d), ANN_EXP);

    // R11 status in parallel mode
    drv_d = 4'hA;
    tick(3);
    chk("R11 stat d field", 32'(stat[3:0]), 32'hA);
    chk("R11 stat upper bits", 32'(stat[7:4]), 32'b0111);

    // R2 directed push 0x3C
    wr_nib(4'hC, "R2 nib0");
    chk("R2 not full after first nibble", 32'(wfull), 0);
    wr_nib(4'h3, "R2 nib1");
    chk("R2 wfull", 32'(wfull), 1);
    chk("R2 wirq", 32'(wirq), 1);
    chk("R2 rx_byte", 32'(rx_byte), 32'(join_nib(4'hC, 4'h3)));

    // R4 hold-off while full, R3 take
    drv_d = 4'h7;
    tick(2);
    wr_strb_n = 1'b0;
    tick(30);
    chk("R4 no ack while full", 32'(ack_oe), 0);
    pulse_take();
    chk("R3 wfull cleared", 32'(wfull), 0);
    chk("R3 wirq cleared", 32'(wirq), 0);
    wait_ack(1'b1, 60, c);
    chk("R4 ack after take", 32'(c < 60), 1);
    wr_strb_n = 1'b1;
    wait_ack(1'b0, 60, c);
    wr_nib(4'h9, "R4 nib1");
    chk("R4 rx_byte", 32'(rx_byte), 32'(join_nib(4'h7, 4'h9)));
    pulse_take();

    // R7 pull with empty register
    rd_strb_n = 1'b0;
    tick(10);
    chk("R7 rirq raised", 32'(rirq), 1);
    chk("R7 no ack while empty", 32'(ack_oe), 0);
    pulse_load(8'h5A);
    chk("R7 rirq cleared by load", 32'(rirq), 0);
    chk("R7 rfull set by load", 32'(rfull), 1);
    rd_byte(got, smin);
    chk("R7 delivered byte", 32'(got), 32'h5A);
    chk("R6 setup clocks", 32'(smin >= SETUP_EXP), 1);
    chk("R5 rfull cleared", 32'(rfull), 0);

    // R8 second load ignored
    pulse_load(8'h11);
    tick(1);
    pulse_load(8'h22);
    rd_byte(got, smin);
    chk("R8 first byte kept", 32'(got), 32'h11);

    // R12 manual control
    man_en = 1'b1; man_ack = 1'b1; man_d_oe = 1'b1; man_d = 4'h6;
    tick(1);
    chk("R12 ack follows man", 32'(ack_oe), 1);
    chk("R12 d_oe follows man", 32'(d_oe), 1);
    chk("R12 d_o follows man", 32'(d_o), 32'h6);
    man_ack = 1'b0; man_d_oe = 1'b0;
    drv_d = 4'h3;
    wr_strb_n = 1'b0;
    tick(12);
    chk("R12 no engine ack", 32'(ack_oe), 0);
    chk("R12 wfull unchanged", 32'(wfull), 0);
    wr_strb_n = 1'b1;
    tick(3);
    man_en = 1'b0;
    tick(3);

    // random traffic, R2 and R5
    for (int k = 0; k < 16; k++) begin
      b = 8'($urandom);
      r = 8'($urandom);
      wr_nib(b[3:0], "R2 rnd nib0");
      wr_nib(b[7:4], "R2 rnd nib1");
      chk("R2 rnd rx_byte", 32'(rx_byte), 32'(b));
      chk("R2 rnd wfull", 32'(wfull), 1);
      pulse_take();
      chk("R3 rnd take", 32'(wfull), 0);
      pulse_load(r);
      rd_byte(got, smin);
      chk("R5 rnd byte", 32'(got), 32'(r));
      chk("R6 rnd setup", 32'(smin >= SETUP_EXP), 1);
      chk("R5 rnd rfull cleared", 32'(rfull), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule